// File: doc/BRIEF.md
# Dual-Bandwidth Zero-Crossing Bit Clock Recovery

This block recovers the bit timing of a received serial stream from its transitions. It runs on an oversampling clock with one sample per cycle and sixteen samples per bit by default. Its input is the hard-sliced receive bit. A phase counter counts through the bit period. At every transition of the sliced bit, the counter is pulled toward the point where the transition was expected. The counter drives a one-cycle mid-bit sample strobe and a recovered data clock. Data is valid on the rising edge of that clock.

An acquire input selects the loop bandwidth. While acquire is high, the loop takes large corrections (half the measured error) so that it pulls in quickly. While acquire is low, it takes single-count corrections, which give the finest timing and the least jitter.

A lock controller has two states, named `HUNT` and `LOCKED`. It counts transitions that land close to the expected boundary and reports lock after eight of them. Its transitions are:
- Reset enters `HUNT`.
- `HUNT` moves to `LOCKED` on the eighth good crossing.
- `LOCKED` returns to `HUNT`, with the count cleared, on a rising edge of acquire.

Top module: `bitclk_recovery`

## Requirements
- R1: After reset the phase counter is 0, `mid_strobe` and `data_clk` are low, and `locked` is low in state `HUNT`.
- R2: With no transition on `rx_bit`, the phase advances by one per cycle modulo 16. The first strobe comes 8 cycles after reset is released, and strobes then repeat every 16 cycles.
- R3: `mid_strobe` is high for exactly one cycle when the phase equals 8. `data_clk` is high for phases 8..15 and low for phases 0..7, so its rising edge coincides with the strobe.
- R4: A transition is a change of `rx_bit` from its previous sample. It is seen at phase p, with signed error e = p for p in 0..7 and e = p-16 for p in 8..15. When e = 0 no correction is applied.
- R5: While `acquire` is 1 (wide mode), a transition moves the next phase to p+1-c. The correction c has magnitude (|e|+1)/2, rounded down, and the sign of e. A positive e (early half) retards the phase; a negative e (late half) advances it.
- R6: While `acquire` is 0 (narrow mode), c is +1 for e > 0, -1 for e < 0 and 0 for e = 0.
- R7: A transition with |e| <= 4 is a good crossing. In `HUNT`, the eighth good crossing since the count was last cleared raises `locked` in the cycle after it is sampled.
- R8: A transition with |e| >= 5 is not counted toward lock.
- R9: `locked` stays high through further crossings. A rising edge of `acquire` clears the count and drops `locked` in the next cycle. Reset also clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Hard-sliced receive bit |
| acquire | input | 1 | 1 selects wide bandwidth; a rising edge restarts lock counting |
| mid_strobe | output | 1 | One-cycle pulse at mid-bit |
| data_clk | output | 1 | Recovered data clock; its rising edge marks valid data |
| locked | output | 1 | High after eight good crossings |

## Verification
The assertions take `rx_bit` and `acquire` to be synchronous to `clk` and free of glitches. They also assume a transition only matters in the cycle in which the sampled value differs from the previous one. The bench changes inputs only on falling edges and holds `rx_bit` steady between deliberate single transitions. Each transition is placed at a chosen phase that is measured from the observed strobe, so every measured correction comes from exactly one crossing.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    typedef enum logic {
        HUNT   = 1'b0,
        LOCKED = 1'b1
    } lock_state_t;
endpackage

// File: rtl/bcr_phase_detect.sv
module bcr_phase_detect #(
    parameter int SPB = 16,
    parameter int WIN = 4,
    localparam int PH_W = $clog2(SPB)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_bit,
    input  logic                   acquire,
    input  logic [PH_W-1:0]        phase,
    output logic                   edge_seen,
    output logic                   good,
    output logic signed [PH_W:0]   corr
);
    localparam int MID = SPB / 2;

    logic                 prev_bit;
    logic signed [PH_W:0] err;
    logic        [PH_W:0] mag;
    logic        [PH_W:0] step;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_bit <= 1'b0;
        else        prev_bit <= rx_bit;
    end

    always_comb begin
        edge_seen = (rx_bit != prev_bit);
        if (phase < PH_W'(MID))
            err = signed'({1'b0, phase});
        else
            err = signed'({1'b0, phase}) - signed'((PH_W+1)'(SPB));
        mag = err[PH_W] ? unsigned'(-err) : unsigned'(err);
        if (acquire)
            step = (mag + (PH_W+1)'(1)) >> 1;
        else
            step = (mag != '0) ? (PH_W+1)'(1) : '0;
        corr = err[PH_W] ? -signed'(step) : signed'(step);
        good = edge_seen && (mag <= (PH_W+1)'(WIN));
    end

    // R8: a crossing counted as good never has the largest possible error
    assert_good_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        good |-> (phase != PH_W'(MID)));
endmodule

// File: rtl/bcr_phase_nco.sv
module bcr_phase_nco #(
    parameter int SPB = 16,
    localparam int PH_W = $clog2(SPB)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   edge_seen,
    input  logic signed [PH_W:0]   corr,
    output logic [PH_W-1:0]        phase,
    output logic                   mid_strobe,
    output logic                   data_clk
);
    localparam int MID = SPB / 2;

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (edge_seen)
            phase_q <= phase_q + PH_W'(1) - corr[PH_W-1:0];
        else
            phase_q <= phase_q + PH_W'(1);
    end

    always_comb begin
        phase      = phase_q;
        mid_strobe = (phase_q == PH_W'(MID));
        data_clk   = (phase_q >= PH_W'(MID));
    end

    assert_free_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_seen |=> (phase_q == PH_W'($past(phase_q) + PH_W'(1))));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mid_strobe |=> !mid_strobe);

    assert_dclk_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_clk) |-> mid_strobe);
endmodule

// File: rtl/bcr_lock_fsm.sv
module bcr_lock_fsm
    import bcr_pkg::*;
#(
    parameter int LOCK_N = 8,
    localparam int CNT_W = $clog2(LOCK_N + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acquire,
    input  logic good,
    output logic locked
);
    lock_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             acq_prev;
    logic             acq_rise;

    assign acq_rise = acquire && !acq_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= HUNT;
            cnt_q    <= '0;
            acq_prev <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            acq_prev <= acquire;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HUNT: begin
                if (acq_rise) begin
                    cnt_d = '0;
                end else if (good) begin
                    if (cnt_q == CNT_W'(LOCK_N - 1)) begin
                        cnt_d   = CNT_W'(LOCK_N);
                        state_d = LOCKED;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            LOCKED: begin
                if (acq_rise) begin
                    cnt_d   = '0;
                    state_d = HUNT;
                end
            end
        endcase
    end

    always_comb begin
        locked = (state_q == LOCKED);
    end

    assert_lock_needs_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(good));

    assert_acq_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acquire) |=> !locked);
endmodule

// File: rtl/bitclk_recovery.sv
module bitclk_recovery #(
    parameter int SPB    = 16,
    parameter int WIN    = 4,
    parameter int LOCK_N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic acquire,
    output logic mid_strobe,
    output logic data_clk,
    output logic locked
);
    localparam int PH_W = $clog2(SPB);

    logic [PH_W-1:0]      phase;
    logic                 edge_seen;
    logic                 good;
    logic signed [PH_W:0] corr;

    bcr_phase_detect #(.SPB(SPB), .WIN(WIN)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .acquire   (acquire),
        .phase     (phase),
        .edge_seen (edge_seen),
        .good      (good),
        .corr      (corr)
    );

    bcr_phase_nco #(.SPB(SPB)) u_nco (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_seen  (edge_seen),
        .corr       (corr),
        .phase      (phase),
        .mid_strobe (mid_strobe),
        .data_clk   (data_clk)
    );

    bcr_lock_fsm #(.LOCK_N(LOCK_N)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .acquire (acquire),
        .good    (good),
        .locked  (locked)
    );

    // R6: in narrow mode one crossing moves the phase by at most one count
    assert_narrow_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !acquire) |=>
            (PH_W'(phase - $past(phase)) inside {PH_W'(0), PH_W'(1), PH_W'(2)}));
endmodule

// File: tb/bitclk_recovery_tb.sv
module bitclk_recovery_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic acquire = 1'b1;
    logic mid_strobe, data_clk, locked;

    int n_checks = 0;
    int n_fail = 0;
    bit lock_after;

    always #2 clk = ~clk;

    bitclk_recovery u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_bit     (rx_bit),
        .acquire    (acquire),
        .mid_strobe (mid_strobe),
        .data_clk   (data_clk),
        .locked     (locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_gap(input int p, input bit wide);
        int e, m, c;
        e = (p < 8) ? p : p - 16;
        m = (e < 0) ? -e : e;
        if (wide) m = (m + 1) / 2;
        else      m = (m != 0) ? 1 : 0;
        c = (e < 0) ? -m : m;
        return ((7 - p + c) % 16 + 16) % 16;
    endfunction

    task automatic wait_strobe();
        int k = 0;
        @(negedge clk);
        while (!mid_strobe && k < 40) begin
            @(negedge clk);
            k++;
        end
    endtask

    // put one transition at phase p; return cycles from the edge to the next strobe
    task automatic hit_phase(input int p, output int n);
        wait_strobe();
        repeat ((p - 8 + 16) % 16) @(negedge clk);
        rx_bit = ~rx_bit;
        @(negedge clk);
        lock_after = locked;
        n = 0;
        while (!mid_strobe && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic t_reset();
        int k = 0;
        check(!mid_strobe && !data_clk && !locked, "R1 reset outputs", {mid_strobe, data_clk, locked}, 0);
        while (!mid_strobe && k < 40) begin
            @(negedge clk);
            k++;
        end
        check(k == 8, "R2 first strobe delay", k, 8);
    endtask

    task automatic t_free_run();
        int k, hi;
        for (int r = 0; r < 3; r++) begin
            k = 0;
            hi = 0;
            @(negedge clk);
            check(!mid_strobe, "R3 strobe one cycle", mid_strobe, 0);
            while (!mid_strobe && k < 40) begin
                if (data_clk) hi++;
                @(negedge clk);
                k++;
            end
            check(k == 15, "R2 strobe period", k + 1, 16);
            check(hi == 7 && data_clk, "R3 data_clk high phases", hi + 1, 8);
        end
    endtask

    task automatic t_wide();
        int n;
        int pts[5] = '{0, 4, 12, 5, 8};
        foreach (pts[i]) begin
            hit_phase(pts[i], n);
            check(n == exp_gap(pts[i], 1'b1), (pts[i] == 0) ? "R4 dead zone wide" : "R5 wide correction",
                  n, exp_gap(pts[i], 1'b1));
        end
    endtask

    task automatic t_narrow();
        int n;
        int pts[4] = '{4, 12, 8, 0};
        @(negedge clk);
        acquire = 1'b0;
        foreach (pts[i]) begin
            hit_phase(pts[i], n);
            check(n == exp_gap(pts[i], 1'b0), (pts[i] == 0) ? "R4 dead zone narrow" : "R6 narrow correction",
                  n, exp_gap(pts[i], 1'b0));
        end
    endtask

    task automatic t_lock();
        int n;
        @(negedge clk);
        acquire = 1'b1;
        @(negedge clk);
        acquire = 1'b0;
        check(!locked, "R9 cleared by acquire", locked, 0);
        for (int i = 0; i < 7; i++) hit_phase(0, n);
        check(!locked, "R7 seven good not locked", locked, 0);
        hit_phase(5, n);
        hit_phase(11, n);
        check(!lock_after && !locked, "R8 far crossings not counted", locked, 0);
        hit_phase(12, n);
        check(lock_after, "R7 eighth good locks", lock_after, 1);
        for (int i = 0; i < 4; i++) hit_phase(0, n);
        check(locked, "R9 lock holds", locked, 1);
        @(negedge clk);
        acquire = 1'b1;
        @(negedge clk);
        check(!locked, "R9 acquire rise drops lock", locked, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_free_run();
        t_wide();
        t_narrow();
        t_lock();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule